// File: doc/BRIEF.md
# PHY Management Register Responder

This block stands in for the management side of an Ethernet PHY as seen from a host. The host owns three words: a control word, a write-data word and a read-data word. Writing the control word with its start flag set launches one transaction against a 32-entry bank of 16-bit PHY registers. The control word names the target PHY address, the register index and the operation. A write copies the write-data word into the bank. A read loads the read-data word, which the host then fetches.

Only one PHY is attached, at a parameter-chosen address (default 7). Requests aimed at any other address see no device. A few registers are not stored but computed on every read from the link input and the advertisement register (index 4): basic status, partner ability, a fixed speed indication and a diagnostic word. Every completed write clears the soft-reset flag (bit 15 of register 0). Bit-level serial timing of the management bus is not modelled.

The host port is a plain register port. It accepts a write on every cycle and gives its read data combinationally, so there is no back-pressure. A transaction is accepted on the cycle the control word is written and finishes on the following clock edge. The host must leave one cycle between commands.

Top module: `phy_mgmt_responder`

## Requirements
- R1: After reset the control word reads 0x00000080 and the write-data and read-data words read 0. The bank holds 0x3100 at index 0, 0x0300 at index 2, 0xE400 at index 3 and 0x01E1 at index 4, and 0 everywhere else.
- R2: Control word fields are: PHY address in bits 28:24, register index in bits 20:16, operation in bits 15:14, start flag in bit 11. Operation 1 writes the low 16 bits of the write-data word into the bank. Operation 2 loads the read-data word. Both take effect on the clock edge after the one that stores the control word. Without the start flag, nothing happens.
- R3: With the start flag set, operations 0 and 3 leave both the read-data word and the bank unchanged.
- R4: A read to a PHY address other than the configured one returns 0xFFFF. A write to such an address changes nothing.
- R5: Reading the control word (host select 0) returns the last value written with bit 7 forced to 1. Host select 1 returns the write-data word, select 2 the read-data word zero-extended, and select 3 returns 0.
- R6: Register 1 reads 0 while link_up is low. While link_up is high it reads 0x782E (bits 14, 13, 12, 11, 5, 3, 2 and 1).
- R7: Register 5 reads 0x4001 OR (register 4 AND 0x01E0).
- R8: Register 17 always reads 0x8000, whatever was written to it.
- R9: Register 18 reads 0 while link_up is low. While link_up is high, bit 10 = reg4[7] OR reg4[8] and bit 11 = reg4[6] OR reg4[8]; all other bits are 0.
- R10: After any completed write, bit 15 of register 0 is 0. This includes a write of a value with that bit set.
- R11: Every register other than 1, 5, 17 and 18 reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Current link state used by the computed registers |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Host word select: 0 control, 1 write data, 2 read data |
| host_wdata | input | 32 | Host write value |
| host_rdata | output | 32 | Host read value for host_sel, combinational |

## Verification
A read result reaches the read-data word two clock edges after the host drives the control write. The first edge stores the command; the second edge executes it. The scoreboard monitor watches the port for a read command with the start flag set and waits one more edge. It then samples host_rdata on the falling edge after that, and compares it against the value the driver queued. Writes, ignored operations and commands without the start flag are confirmed two edges later, either by a following read or by fetching the read-data word directly. The driver never changes inputs on a falling edge where the monitor samples.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int MGMT_DW      = 16;
  localparam int REG_AW       = 5;
  localparam int REG_COUNT    = 1 << REG_AW;
  localparam int HOST_W       = 32;

  // Control word field positions (decoded by the responder)
  localparam int CW_PHY_LSB   = 24;
  localparam int CW_REG_LSB   = 16;
  localparam int CW_OP_LSB    = 14;
  localparam int CW_START_BIT = 11;
  localparam int CW_READY_BIT = 7;

  localparam logic [MGMT_DW-1:0] NO_DEVICE = 16'hFFFF;
  localparam int SOFT_RST_BIT = 15;

  typedef enum logic [1:0] {
    OP_IDLE0 = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_IDLE3 = 2'd3
  } mgmt_op_e;

  typedef struct packed {
    logic              valid;
    logic              hit;
    logic [REG_AW-1:0] regn;
    mgmt_op_e          op;
  } mgmt_req_t;

  function automatic logic [MGMT_DW-1:0] reg_reset_value(int idx);
    case (idx)
      0:       return 16'h3100;
      2:       return 16'h0300;
      3:       return 16'hE400;
      4:       return 16'h01E1;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/mgmt_cmd_decode.sv
module mgmt_cmd_decode
  import phy_mgmt_pkg::*;
#(
  parameter int PHY_ADDR = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              start,
  input  logic [4:0]        phy,
  input  logic [REG_AW-1:0] regn,
  input  logic [1:0]        op,
  output mgmt_req_t         req
);
  localparam logic [4:0] OWN_ADDR = 5'(PHY_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req <= '0;
    end else begin
      req.valid <= cmd_we & start;
      req.hit   <= (phy == OWN_ADDR);
      req.regn  <= regn;
      req.op    <= mgmt_op_e'(op);
    end
  end
endmodule

// File: rtl/mgmt_reg_bank.sv
module mgmt_reg_bank
  import phy_mgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [REG_AW-1:0]  addr,
  input  logic [MGMT_DW-1:0] wdata,
  output logic [MGMT_DW-1:0] rdata,
  output logic [MGMT_DW-1:0] adv,
  output logic               soft_bit
);
  localparam logic [MGMT_DW-1:0] SOFT_MASK = ~(MGMT_DW'(1) << SOFT_RST_BIT);

  logic [MGMT_DW-1:0] regs [REG_COUNT];

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_entry
    if (i == 0) begin : g_ctrl
      always_ff @(posedge clk) begin
        if (!rst_n)                         regs[i] <= reg_reset_value(i);
        else if (we && addr == REG_AW'(i))  regs[i] <= wdata & SOFT_MASK;
        else if (we)                        regs[i] <= regs[i] & SOFT_MASK;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)                         regs[i] <= reg_reset_value(i);
        else if (we && addr == REG_AW'(i))  regs[i] <= wdata;
      end
    end
  end

  assign rdata    = regs[addr];
  assign adv      = regs[4];
  assign soft_bit = regs[0][SOFT_RST_BIT];
endmodule

// File: rtl/mgmt_status_view.sv
module mgmt_status_view
  import phy_mgmt_pkg::*;
(
  input  logic [REG_AW-1:0]  regn,
  input  logic [MGMT_DW-1:0] stored,
  input  logic [MGMT_DW-1:0] adv,
  input  logic               link_up,
  output logic [MGMT_DW-1:0] view
);
  localparam logic [MGMT_DW-1:0] STATUS_UP = 16'h782E;
  localparam logic [MGMT_DW-1:0] ABIL_MASK = 16'h01E0;
  localparam logic [MGMT_DW-1:0] ABIL_BASE = 16'h4001;
  localparam logic [MGMT_DW-1:0] SPEED_FIX = 16'h8000;

  logic fast, full;
  assign fast = adv[7] | adv[8];
  assign full = adv[6] | adv[8];

  always_comb begin
    case (regn)
      5'd1:    view = link_up ? STATUS_UP : '0;
      5'd5:    view = ABIL_BASE | (adv & ABIL_MASK);
      5'd17:   view = SPEED_FIX;
      5'd18:   view = link_up ? {4'b0, full, fast, 10'b0} : '0;
      default: view = stored;
    endcase
  end
endmodule

// File: rtl/phy_mgmt_responder.sv
module phy_mgmt_responder
  import phy_mgmt_pkg::*;
#(
  parameter int PHY_ADDR = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata
);
  logic [HOST_W-1:0]  ctl_q, wd_q;
  logic [MGMT_DW-1:0] rd_q;
  mgmt_req_t          req_q;
  logic [MGMT_DW-1:0] bank_rd, bank_adv, view;
  logic               bank_we, soft_bit;
  logic               ctl_we;

  logic               exec_valid, exec_hit;
  logic [1:0]         exec_op;
  logic [REG_AW-1:0]  exec_regn;

  assign ctl_we = host_we && host_sel == 2'd0;

  mgmt_cmd_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd_we(ctl_we),
    .start (host_wdata[CW_START_BIT]),
    .phy   (host_wdata[CW_PHY_LSB +: 5]),
    .regn  (host_wdata[CW_REG_LSB +: REG_AW]),
    .op    (host_wdata[CW_OP_LSB +: 2]),
    .req   (req_q)
  );

  assign exec_valid = req_q.valid;
  assign exec_hit   = req_q.hit;
  assign exec_op    = req_q.op;
  assign exec_regn  = req_q.regn;

  assign bank_we = exec_valid && exec_hit && req_q.op == OP_WRITE;

  mgmt_reg_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bank_we),
    .addr    (exec_regn),
    .wdata   (wd_q[MGMT_DW-1:0]),
    .rdata   (bank_rd),
    .adv     (bank_adv),
    .soft_bit(soft_bit)
  );

  mgmt_status_view u_view (
    .regn   (exec_regn),
    .stored (bank_rd),
    .adv    (bank_adv),
    .link_up(link_up),
    .view   (view)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      wd_q  <= '0;
      rd_q  <= '0;
    end else begin
      if (ctl_we)                             ctl_q <= host_wdata;
      if (host_we && host_sel == 2'd1)        wd_q  <= host_wdata;
      if (exec_valid && req_q.op == OP_READ)  rd_q  <= exec_hit ? view : NO_DEVICE;
    end
  end

  always_comb begin
    case (host_sel)
      2'd0:    host_rdata = ctl_q | (HOST_W'(1) << CW_READY_BIT);
      2'd1:    host_rdata = wd_q;
      2'd2:    host_rdata = HOST_W'(rd_q);
      default: host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/phy_mgmt_checker.sv
module phy_mgmt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        link_up,
  input logic [1:0]  host_sel,
  input logic [31:0] host_rdata,
  input logic        exec_valid,
  input logic        exec_hit,
  input logic [1:0]  exec_op,
  input logic [4:0]  exec_regn,
  input logic [15:0] rd_q,
  input logic        soft_bit
);
  a_r5_ready_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel == 2'd0) |-> host_rdata[7]);

  a_r10_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && exec_hit && exec_op == 2'd1) |=> !soft_bit);

  a_r3_ignored_op: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && (exec_op == 2'd0 || exec_op == 2'd3)) |=> $stable(rd_q));

  a_r4_absent_phy: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && !exec_hit && exec_op == 2'd2) |=> rd_q == 16'hFFFF);

  a_r8_fixed_speed: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && exec_hit && exec_op == 2'd2 && exec_regn == 5'd17) |=> rd_q == 16'h8000);

  a_r6_link_down: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && exec_hit && exec_op == 2'd2 && exec_regn == 5'd1 && !link_up) |=> rd_q == 16'h0000);
endmodule

bind phy_mgmt_responder phy_mgmt_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .link_up   (link_up),
  .host_sel  (host_sel),
  .host_rdata(host_rdata),
  .exec_valid(exec_valid),
  .exec_hit  (exec_hit),
  .exec_op   (exec_op),
  .exec_regn (exec_regn),
  .rd_q      (rd_q),
  .soft_bit  (soft_bit)
);

// File: tb/tb_phy_mgmt_responder.sv
module tb_phy_mgmt_responder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up = 1'b1;
  logic        host_we = 1'b0;
  logic [1:0]  host_sel = 2'd2;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_mgmt_responder #(.PHY_ADDR(7)) dut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up),
    .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(int phy, int regn, int op, bit go);
    return (32'(phy) << 24) | (32'(regn) << 16) | (32'(op) << 14) | (32'(go) << 11);
  endfunction

  task automatic host_write(logic [1:0] sel, logic [31:0] data);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = data;
    @(negedge clk);
    host_we = 1'b0; host_sel = 2'd2;
  endtask

  task automatic command(logic [31:0] word);
    host_write(2'd0, word);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic phy_read(int phy, int regn, logic [15:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    command(cw(phy, regn, 2, 1'b1));
  endtask

  task automatic phy_write(int phy, int regn, logic [15:0] data);
    host_write(2'd1, 32'(data));
    command(cw(phy, regn, 1, 1'b1));
  endtask

  task automatic peek(logic [1:0] sel, logic [31:0] exp, string tag);
    @(negedge clk);
    host_sel = sel;
    #1;
    chk(tag, host_rdata, exp);
  endtask

  // Monitor: a started read command is due one edge after the storing edge
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && host_we && host_sel == 2'd0 && host_wdata[11] && host_wdata[15:14] == 2'd2) begin
        @(posedge clk);
        @(negedge clk);
        if (exp_q.size() == 0) begin
          chk("monitor: unexpected read", 32'hDEAD, 32'h0);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, {16'h0, host_rdata[15:0]}, {16'h0, e});
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R5 reset state of host words
    peek(2'd0, 32'h0000_0080, "R1 control word after reset");
    peek(2'd1, 32'h0, "R1 write-data after reset");
    peek(2'd2, 32'h0, "R1 read-data after reset");
    peek(2'd3, 32'h0, "R5 unused select");

    // R1 bank reset values
    phy_read(7, 0, 16'h3100, "R1 reg0 reset");
    phy_read(7, 2, 16'h0300, "R1 reg2 reset");
    phy_read(7, 3, 16'hE400, "R1 reg3 reset");
    phy_read(7, 4, 16'h01E1, "R1 reg4 reset");
    phy_read(7, 9, 16'h0000, "R1 reg9 reset");

    // R5 control readback with ready bit forced
    peek(2'd0, cw(7, 9, 2, 1'b1) | 32'h80, "R5 control readback");

    // Computed registers with link up
    phy_read(7, 1,  16'h782E, "R6 status link up");
    phy_read(7, 5,  16'h41E1, "R7 ability reset adv");
    phy_read(7, 17, 16'h8000, "R8 speed fixed");
    phy_read(7, 18, 16'h0C00, "R9 diag reset adv");

    // Link down
    link_up = 1'b0;
    phy_read(7, 1,  16'h0000, "R6 status link down");
    phy_read(7, 18, 16'h0000, "R9 diag link down");
    phy_read(7, 17, 16'h8000, "R8 speed link down");
    link_up = 1'b1;

    // Advertisement variants
    phy_write(7, 4, 16'h0080);
    phy_read(7, 18, 16'h0400, "R9 100 half only");
    phy_read(7, 5,  16'h4081, "R7 copy 0x0080");
    phy_write(7, 4, 16'h0040);
    phy_read(7, 18, 16'h0800, "R9 10 full only");
    phy_read(7, 5,  16'h4041, "R7 copy 0x0040");
    phy_write(7, 4, 16'h0100);
    phy_read(7, 18, 16'h0C00, "R9 100 full");
    phy_write(7, 4, 16'hFFFF);
    phy_read(7, 5,  16'h41E1, "R7 masked copy");
    phy_read(7, 4,  16'hFFFF, "R11 reg4 readback");

    // R10 soft reset auto-clear
    phy_write(7, 0, 16'h9234);
    phy_read(7, 0, 16'h1234, "R10 soft bit cleared");

    // R11 plain storage, R8 write has no effect
    phy_write(7, 9, 16'hBEEF);
    phy_read(7, 9, 16'hBEEF, "R11 reg9 readback");
    phy_write(7, 31, 16'h1357);
    phy_read(7, 31, 16'h1357, "R11 reg31 readback");
    phy_write(7, 17, 16'h1111);
    phy_read(7, 17, 16'h8000, "R8 write ignored");

    // R4 absent PHY
    phy_read(3, 2, 16'hFFFF, "R4 absent read");
    phy_write(3, 9, 16'h0000);
    phy_read(7, 9, 16'hBEEF, "R4 absent write ignored");

    // R3 ignored operations (read-data holds 0xBEEF)
    host_write(2'd1, 32'h0000_0000);
    command(cw(7, 9, 0, 1'b1));
    peek(2'd2, 32'h0000_BEEF, "R3 op0 read-data kept");
    command(cw(7, 2, 3, 1'b1));
    peek(2'd2, 32'h0000_BEEF, "R3 op3 read-data kept");
    phy_read(7, 9, 16'hBEEF, "R3 bank unchanged");

    // R2 no start flag
    command(cw(7, 9, 1, 1'b0));
    command(cw(7, 3, 2, 1'b0));
    peek(2'd2, 32'h0000_BEEF, "R2 read without start");
    phy_read(7, 9, 16'hBEEF, "R2 write without start");
    phy_read(7, 2, 16'h0300, "R2 field decode reg2");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) chk("scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule